// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. It retires one multiplier bit per clock cycle. Each cycle it looks at the lowest multiplier bit together with a trailing recoding bit. From that pair it chooses to add the multiplicand to an accumulator, subtract it, or leave the accumulator unchanged. It then shifts the chain {accumulator, multiplier, recoding bit} one place to the right, keeping the sign. Signed operands are handled directly, so there is no sign detection and no magnitude conversion.

A client applies both operands with a one-cycle `start` pulse while the block is idle. `busy` stays high for the whole operation. `done` pulses for one cycle when the product is ready. Internally the accumulator is one bit wider than the operands. This guard bit keeps a multiplicand equal to the most negative value correct, and it never reaches the output.

The control path has three named states:
- `ST_IDLE` waits for a start.
- `ST_RUN` performs one iteration per cycle.
- `ST_DONE` presents the result for one cycle.

The transitions are:
- `ST_IDLE` to `ST_RUN` on an accepted start (the load transition).
- `ST_RUN` to itself while iterations remain.
- `ST_RUN` to `ST_DONE` after the iteration whose counter value is `WIDTH-1` (the last-shift transition).
- `ST_DONE` to `ST_IDLE` unconditionally (the release transition).
- Any state to `ST_IDLE` on reset.

Top module: `booth_seq_mult`

## Requirements
- R1: `rst` is synchronous and active-high. One clock edge with `rst` high puts the block in `ST_IDLE` with `busy` and `done` low. A reset during an operation abandons it, and no `done` pulse follows.
- R2: A `start` sampled high in `ST_IDLE` captures `mcand` and `mplier`. `busy` is high from the next cycle for exactly `WIDTH+1` cycles: `WIDTH` iteration cycles followed by one result cycle.
- R3: The product read while `done` is high equals the signed product of the captured operands. This holds for every operand value, including 0, -1, the most positive value and the most negative value.
- R4: `done` is high for exactly one cycle. That cycle is the `(WIDTH+1)`th cycle after the edge that accepted `start`.
- R5: `start` is ignored while `busy` is high. Operand values or `start` pulses applied during an operation do not change its product or its timing.
- R6: Each iteration decodes the pair {multiplier LSB, recoding bit}. 01 adds the multiplicand, 10 subtracts it (adding its inverse plus one, with the carry dropped), and 00 and 11 leave the accumulator unchanged.
- R7: After each iteration, the accumulator, multiplier register and recoding bit shift right by one as a single chain. The accumulator sign bit is replicated and the accumulator LSB enters the multiplier MSB. `product` always shows {accumulator low `WIDTH` bits, multiplier register}. For `WIDTH`=4 and -3 times 5, it reads 0x05 after the load, then 0x1A, 0xF5, 0x12 and 0xF1 after iterations 1 to 4.
- R8: The state register only ever holds `ST_IDLE`, `ST_RUN` or `ST_DONE`, following the transitions listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; honoured only when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Operation in progress (iteration and result cycles) |
| done | output | 1 | One-cycle pulse; product valid |
| product | output | 2*WIDTH | Signed product, live view of the shift chain |

## Verification
At four-bit width, every operand pair is tried, which covers all sixteen recoding sequences and every pairing of sign cases. At eight and sixteen bits, random pairs are run after a fixed grid of 0, 1, -1, the most positive and the most negative value. The most negative multiplicand is the pattern that separates a guarded accumulator from an unguarded one. The -3 times 5 trace is compared at every iteration, and a negative running accumulator there is what exposes a logical shift. Start pulses with fresh operands during an operation, and a reset in the middle of a run, show that only an idle, unreset block accepts work.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } booth_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_t;

endpackage

// File: rtl/booth_decoder.sv
module booth_decoder
    import booth_pkg::*;
(
    input  logic      mr_lsb,
    input  logic      rec_bit,
    output booth_op_t op
);
    always_comb begin
        unique case ({mr_lsb, rec_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] mc,
    input  booth_op_t     op,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] operand;
    logic [AW-1:0] cin;

    always_comb begin
        operand = (op == OP_SUB) ? ~mc : mc;
        cin     = {{(AW-1){1'b0}}, (op == OP_SUB)};
        if (op == OP_NONE)
            sum = acc;
        else
            sum = acc + operand + cin;
    end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic run
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    booth_state_t  state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk) begin
        if (rst || load) cnt_q <= '0;
        else if (run)    cnt_q <= cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        load = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN:  begin busy = 1'b1; run = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done));
    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start) |=> busy);
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q == LAST) |=> done);
    a_r8_legal_state: assert property (@(posedge clk) disable iff (rst)
        state_q inside {ST_IDLE, ST_RUN, ST_DONE});
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WIDTH-1:0]     mcand,
    input  logic [WIDTH-1:0]     mplier,
    output logic                 busy,
    output logic                 done,
    output logic [2*WIDTH-1:0]   product
);
    localparam int AW = WIDTH + 1;

    logic            load, run;
    logic [AW-1:0]   mc_q, acc_q, sum;
    logic [WIDTH-1:0] mr_q;
    logic            rec_q;
    booth_op_t       op;

    booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .load(load), .run(run)
    );

    booth_decoder u_dec (
        .mr_lsb(mr_q[0]), .rec_bit(rec_q), .op(op)
    );

    booth_addsub #(.AW(AW)) u_alu (
        .acc(acc_q), .mc(mc_q), .op(op), .sum(sum)
    );

    // shift chain {acc, multiplier, recoding bit}
    always_ff @(posedge clk) begin
        if (rst) begin
            mc_q  <= '0;
            acc_q <= '0;
            mr_q  <= '0;
            rec_q <= 1'b0;
        end else if (load) begin
            mc_q  <= {mcand[WIDTH-1], mcand};
            acc_q <= '0;
            mr_q  <= mplier;
            rec_q <= 1'b0;
        end else if (run) begin
            acc_q <= {sum[AW-1], sum[AW-1:1]};
            mr_q  <= {sum[0], mr_q[WIDTH-1:1]};
            rec_q <= mr_q[0];
        end
    end

    assign product = {acc_q[WIDTH-1:0], mr_q};

    a_r5_operand_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mc_q));
    a_r7_sign_kept: assert property (@(posedge clk) disable iff (rst)
        run |=> (acc_q[AW-1] == $past(sum[AW-1]) && acc_q[AW-2] == $past(sum[AW-1])));
    a_r7_lsb_into_mr: assert property (@(posedge clk) disable iff (rst)
        run |=> (mr_q[WIDTH-1] == $past(sum[0]) && rec_q == $past(mr_q[0])));
    a_r6_equal_pair_no_op: assert property (@(posedge clk) disable iff (rst)
        (run && mr_q[0] == rec_q) |=>
            acc_q == {$past(acc_q[AW-1]), $past(acc_q[AW-1:1])});
endmodule

// File: tb/tb_booth_seq_mult.sv
module tb_booth_seq_mult;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] a16 = '0, b16 = '0;
    logic busy4, done4, busy8, done8, busy16, done16;
    logic [7:0]  p4;
    logic [15:0] p8;
    logic [31:0] p16;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    booth_seq_mult #(.WIDTH(8)) dut (
        .clk(clk), .rst(rst), .start(start), .mcand(a8), .mplier(b8),
        .busy(busy8), .done(done8), .product(p8));
    booth_seq_mult #(.WIDTH(4)) dut_n4 (
        .clk(clk), .rst(rst), .start(start), .mcand(a4), .mplier(b4),
        .busy(busy4), .done(done4), .product(p4));
    booth_seq_mult #(.WIDTH(16)) dut_n16 (
        .clk(clk), .rst(rst), .start(start), .mcand(a16), .mplier(b16),
        .busy(busy16), .done(done16), .product(p16));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] corner(input int idx, input int w);
        case (idx)
            0: corner = 16'h0000;
            1: corner = 16'hFFFF;
            2: corner = 16'(1 << (w - 1));
            3: corner = 16'((1 << (w - 1)) - 1);
            default: corner = 16'h0001;
        endcase
    endfunction

    // one operation on all three widths; reference compared every cycle
    task automatic run_op(input logic [3:0] x4, input logic [3:0] y4,
                          input logic [7:0] x8, input logic [7:0] y8,
                          input logic [15:0] x16, input logic [15:0] y16,
                          input bit poke, input bit trace);
        longint e4, e8, e16;
        e4  = longint'($signed(x4))  * longint'($signed(y4));
        e8  = longint'($signed(x8))  * longint'($signed(y8));
        e16 = longint'($signed(x16)) * longint'($signed(y16));
        @(negedge clk);
        a4 = x4; b4 = y4; a8 = x8; b8 = y8; a16 = x16; b16 = y16;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 18; k++) begin
            // R2 / R4: cycle-exact busy and done against the schedule
            chk(busy4  == (k <= 4),  "R2 busy w4",  busy4,  (k <= 4));
            chk(done4  == (k == 4),  "R4 done w4",  done4,  (k == 4));
            chk(busy8  == (k <= 8),  "R2 busy w8",  busy8,  (k <= 8));
            chk(done8  == (k == 8),  "R4 done w8",  done8,  (k == 8));
            chk(busy16 == (k <= 16), "R2 busy w16", busy16, (k <= 16));
            chk(done16 == (k == 16), "R4 done w16", done16, (k == 16));
            if (k == 4)  chk(p4  == e4[7:0],   "R3 product w4",  p4,  e4[7:0]);
            if (k == 8)  chk(p8  == e8[15:0],  "R3 product w8",  p8,  e8[15:0]);
            if (k == 16) chk(p16 == e16[31:0], "R3 product w16", p16, e16[31:0]);
            if (trace) begin
                // R7: chain view after load and after each iteration
                case (k)
                    0: chk(p4 == 8'h05, "R7 trace load", p4, 8'h05);
                    1: chk(p4 == 8'h1A, "R7 trace it1",  p4, 8'h1A);
                    2: chk(p4 == 8'hF5, "R7 trace it2",  p4, 8'hF5);
                    3: chk(p4 == 8'h12, "R7 trace it3",  p4, 8'h12);
                    4: chk(p4 == 8'hF1, "R7 trace it4",  p4, 8'hF1);
                    default: ;
                endcase
            end
            if (poke) begin
                // R5: fresh operands and start while busy
                start = (k >= 1 && k <= 2);
                a4 = ~x4; b4 = 4'h8; a8 = ~x8; b8 = 8'h80; a16 = ~x16; b16 = 16'h8000;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                checks++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy4 && !busy8 && !busy16, "R1 busy after reset", {busy4, busy8, busy16}, 0);
        chk(!done4 && !done8 && !done16, "R1 done after reset", {done4, done8, done16}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R7: -3 x 5 trace at WIDTH 4, R6 exercised by its add/sub steps
        run_op(4'hD, 4'h5, 8'hFD, 8'h05, 16'hFFFD, 16'h0005, 1'b0, 1'b1);

        // R3, R6: exhaustive width 4, corner grid then random for 8 and 16
        for (int i = 0; i < 256; i++) begin
            logic [7:0]  r8a, r8b;
            logic [15:0] r16a, r16b;
            if (i < 25) begin
                r8a  = 8'(corner(i / 5, 8));   r8b  = 8'(corner(i % 5, 8));
                r16a = corner(i / 5, 16);      r16b = corner(i % 5, 16);
            end else begin
                r8a  = 8'($urandom);  r8b  = 8'($urandom);
                r16a = 16'($urandom); r16b = 16'($urandom);
            end
            run_op(4'(i >> 4), 4'(i), r8a, r8b, r16a, r16b, 1'b0, 1'b0);
        end

        // R5: start during an operation is ignored
        run_op(4'h8, 4'h8, 8'h80, 8'h7F, 16'h8000, 16'h8000, 1'b1, 1'b0);
        run_op(4'h3, 4'hA, 8'h5C, 8'hE1, 16'h1234, 16'hBEEF, 1'b1, 1'b0);

        // R1: reset in the middle of a run abandons it
        @(negedge clk);
        a4 = 4'h7; b4 = 4'h7; a8 = 8'h11; b8 = 8'h22; a16 = 16'h3; b16 = 16'h4;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy4 && !busy8 && !busy16, "R1 busy after mid reset", {busy4, busy8, busy16}, 0);
        for (int k = 0; k < 20; k++) begin
            chk(!done4 && !done8 && !done16, "R1 no done after abort", {done4, done8, done16}, 0);
            @(negedge clk);
        end
        run_op(4'h9, 4'h6, 8'h81, 8'hFF, 16'h7FFF, 16'h8000, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule